// File: doc/BRIEF.md
# Exception Entry and Privilege Sequencer

This block tracks the privilege state of a 32-bit core and runs its exception entry. It owns a 16-bit status word, a table base register and a pair of stack pointers. When an exception request arrives, it stores the current status word and raises supervisor state. For interrupts it also clears the master bit and loads the priority mask. It then pushes a two-word frame through a memory write port and fetches the handler address through a memory read port with one cycle of latency. Finally it presents the handler program counter with a one-cycle `done` pulse.

While idle, the block also applies return-from-exception loads, status writes, base register writes and writes to the active stack pointer. When the supervisor bit changes, the active and other stack pointers trade places. If a supervisor-only operation is attempted in user state (a return or a base write), the block turns it into a privilege-violation exception.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status word is 0x2700, both stack pointers and the table base are zero, and `busy` and `done` are low.
- R2: An accepted exception sets status bit 13 (supervisor) and clears bit 15 (trace) in the cycle after acceptance. For a non-interrupt exception, bits 12 and 10:8 keep their prior value.
- R3: An accepted interrupt (`exc_irq` high) clears status bit 12 and loads bits 10:8 with `exc_lvl`.
- R4: Entry makes exactly two writes, at the active pointer minus 8 and then minus 4. The first word is {4'h4, 4'h0, vector[7:0], saved status[15:0]} (most significant first) and the second is the request's program counter. The active pointer ends 8 lower.
- R5: After the two writes, one read is issued at base + 4 × vector. The returned word appears on `handler_pc` together with a one-cycle `done` pulse, four cycles after the accept edge.
- R6: A base write in supervisor state keeps only bit 23 of the written value, so the table base is always 0x000000 or 0x800000.
- R7: Whenever status bit 13 changes value, the active and other stack pointers exchange contents.
- R8: A return load, or a status write in supervisor state, loads the full value with bits 14 and 11 forced to zero. Bit 13 of that value selects the resulting mode.
- R9: A status write in user state changes bits 7:0 only.
- R10: A return request or a base write in user state starts an exception with vector 8, treated as non-interrupt, stacking `exc_pc`. Neither the status load nor the base update takes place.
- R11: `busy` is high from the accept edge until the handler is delivered. Exception, return, status, base and pointer requests presented while busy are ignored.
- R12: A stack pointer write in idle state, with no other request, loads the active pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request |
| exc_vec | input | 8 | Vector number of the request |
| exc_irq | input | 1 | Request is an interrupt |
| exc_lvl | input | 3 | Interrupt level |
| exc_pc | input | 32 | Program counter to stack |
| rte_req | input | 1 | Return-from-exception request |
| rte_sr | input | 16 | Status value restored by the return |
| sr_wr_en | input | 1 | Status write strobe |
| sr_wr_data | input | 16 | Status write value |
| vbr_wr_en | input | 1 | Table base write strobe |
| vbr_wr_data | input | 32 | Table base write value |
| sp_wr_en | input | 1 | Active stack pointer write strobe |
| sp_wr_data | input | 32 | Active stack pointer write value |
| mem_we | output | 1 | Frame write strobe |
| mem_waddr | output | 32 | Frame write address |
| mem_wdata | output | 32 | Frame write data |
| mem_re | output | 1 | Vector read strobe |
| mem_raddr | output | 32 | Vector read address |
| mem_rdata | input | 32 | Vector read data, valid one cycle after `mem_re` |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Handler address delivered (one cycle) |
| handler_pc | output | 32 | Handler program counter |
| sr | output | 16 | Current status word |
| supervisor | output | 1 | Supervisor state |
| active_sp | output | 32 | Active stack pointer |

## Verification
The bench builds the block with its default parameters: 8-bit vectors, privilege vector 8, reset status 0x2700 and a base mask that keeps only bit 23. With these values, both table locations and every vector up to 255 can be reached. Frame words and fetch addresses can be predicted exactly from the bench's own model. Because the reset status starts in supervisor state, the bench can drop to user state with a status write and later come back through an exception. This exercises the pointer exchange in both directions, together with the privilege-violation path and the user-state byte-only write.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH0,
    S_PUSH1,
    S_FETCH,
    S_LATCH
  } seq_st_t;

  localparam int unsigned SR_W      = 16;
  localparam int unsigned SR_TRACE  = 15;
  localparam int unsigned SR_SUPER  = 13;
  localparam int unsigned SR_MASTER = 12;
  localparam logic [15:0] SR_KEEP   = 16'hB7FF;
  localparam logic [3:0]  FRAME_FMT = 4'h4;
  localparam logic [31:0] FRAME_BYTES = 32'd8;
endpackage

// File: rtl/exc_sr_reg.sv
module exc_sr_reg
  import exc_pkg::*;
#(
  parameter logic [15:0] RESET_SR = 16'h2700
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        entry,
  input  logic        ent_irq,
  input  logic [2:0]  lvl,
  input  logic        rte_ld,
  input  logic [15:0] rte_val,
  input  logic        srw,
  input  logic [15:0] wr_val,
  output logic [15:0] sr_q,
  output logic        swap
);
  logic [15:0] sr_d;
  logic        sr_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = 1'b0;
    if (entry) begin
      sr_en = 1'b1;
      sr_d[SR_SUPER] = 1'b1;
      sr_d[SR_TRACE] = 1'b0;
      if (ent_irq) begin
        sr_d[SR_MASTER] = 1'b0;
        sr_d[10:8]      = lvl;
      end
    end else if (rte_ld) begin
      sr_en = 1'b1;
      sr_d  = rte_val & SR_KEEP;
    end else if (srw) begin
      sr_en = 1'b1;
      if (sr_q[SR_SUPER]) sr_d = wr_val & SR_KEEP;
      else                sr_d = {sr_q[15:8], wr_val[7:0]};
    end
    swap = sr_en & (sr_d[SR_SUPER] ^ sr_q[SR_SUPER]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= RESET_SR & SR_KEEP;
    else if (sr_en) sr_q <= sr_d;
  end

  // R2
  entry_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (sr_q[SR_SUPER] && !sr_q[SR_TRACE]));

  // R3
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && ent_irq) |=> (sr_q[10:8] == $past(lvl) && !sr_q[SR_MASTER]));

  // R8
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q[14] == 1'b0 && sr_q[11] == 1'b0));

  // R9
  user_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srw && !entry && !rte_ld && !sr_q[SR_SUPER]) |=> (sr_q[15:8] == $past(sr_q[15:8])));
endmodule

// File: rtl/exc_sp_bank.sv
module exc_sp_bank
  import exc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap,
  input  logic          dec,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] act_q,
  output logic [AW-1:0] oth_q
);
  logic [AW-1:0] act_d, oth_d;
  logic          en;

  always_comb begin
    act_d = act_q;
    oth_d = oth_q;
    en    = swap | dec | wr_en;
    if (swap) begin
      act_d = oth_q;
      oth_d = act_q;
    end else if (dec) begin
      act_d = act_q - AW'(FRAME_BYTES);
    end else if (wr_en) begin
      act_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      oth_q <= '0;
    end else if (en) begin
      act_q <= act_d;
      oth_q <= oth_d;
    end
  end

  // R7
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (act_q == $past(oth_q) && oth_q == $past(act_q)));

  // R4
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !swap) |=> (act_q == $past(act_q) - AW'(FRAME_BYTES)));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned VW       = 8,
  parameter int unsigned PRIV_VEC = 8,
  parameter logic [31:0] VBR_MASK = 32'h0080_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          exc_irq,
  input  logic [31:0]   exc_pc,
  input  logic          rte_req,
  input  logic          sr_wr_en,
  input  logic          vbr_wr_en,
  input  logic [31:0]   vbr_wr_data,
  input  logic          sp_wr_en,
  input  logic [15:0]   sr_q,
  input  logic [31:0]   act_sp,
  input  logic [31:0]   mem_rdata,
  output logic          entry,
  output logic          ent_irq,
  output logic          rte_ld,
  output logic          srw,
  output logic          sp_ld,
  output logic          dec,
  output logic          mem_we,
  output logic [31:0]   mem_waddr,
  output logic [31:0]   mem_wdata,
  output logic          mem_re,
  output logic [31:0]   mem_raddr,
  output logic          busy,
  output logic          done,
  output logic [31:0]   handler_pc
);
  localparam int unsigned PADW = 12 - VW;

  seq_st_t       st_q, st_d;
  logic [VW-1:0] vec_q, ent_vec;
  logic [31:0]   pc_q, vbr_q;
  logic [15:0]   saved_q;
  logic          done_q;
  logic          idle, viol, take, vbr_ld;

  always_comb begin
    idle    = (st_q == S_IDLE);
    viol    = ~sr_q[SR_SUPER] & (rte_req | vbr_wr_en);
    take    = exc_req | viol;
    entry   = idle & take;
    ent_irq = exc_req & exc_irq;
    ent_vec = exc_req ? exc_vec : VW'(PRIV_VEC);
    rte_ld  = idle & ~take & rte_req;
    srw     = idle & ~take & ~rte_req & sr_wr_en;
    vbr_ld  = idle & ~take & ~rte_req & vbr_wr_en;
    sp_ld   = idle & ~take & ~rte_req & ~sr_wr_en & ~vbr_wr_en & sp_wr_en;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (entry) st_d = S_PUSH0;
      S_PUSH0: st_d = S_PUSH1;
      S_PUSH1: st_d = S_FETCH;
      S_FETCH: st_d = S_LATCH;
      S_LATCH: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    dec       = (st_q == S_PUSH0);
    mem_we    = (st_q == S_PUSH0) | (st_q == S_PUSH1);
    mem_waddr = (st_q == S_PUSH0) ? act_sp - FRAME_BYTES : act_sp + 32'd4;
    mem_wdata = (st_q == S_PUSH0) ? {FRAME_FMT, {PADW{1'b0}}, vec_q, saved_q} : pc_q;
    mem_re    = (st_q == S_FETCH);
    mem_raddr = vbr_q + {{(30-VW){1'b0}}, vec_q, 2'b00};
    busy      = ~idle;
    done      = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      vec_q      <= '0;
      pc_q       <= '0;
      saved_q    <= '0;
      vbr_q      <= '0;
      done_q     <= 1'b0;
      handler_pc <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == S_LATCH);
      if (entry) begin
        vec_q   <= ent_vec;
        pc_q    <= exc_pc;
        saved_q <= sr_q;
      end
      if (vbr_ld) vbr_q <= vbr_wr_data & VBR_MASK;
      if (st_q == S_LATCH) handler_pc <= mem_rdata;
    end
  end

  // R11
  busy_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> busy);

  // R4
  second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PUSH0) |=> (mem_we && mem_waddr == $past(mem_waddr) + 32'd4));

  // R5
  fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (!mem_re ##1 done_q));

  // R6
  vbr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vbr_q & ~VBR_MASK) == 32'd0));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned VW       = 8,
  parameter int unsigned PRIV_VEC = 8,
  parameter logic [15:0] RESET_SR = 16'h2700,
  parameter logic [31:0] VBR_MASK = 32'h0080_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          exc_irq,
  input  logic [2:0]    exc_lvl,
  input  logic [31:0]   exc_pc,
  input  logic          rte_req,
  input  logic [15:0]   rte_sr,
  input  logic          sr_wr_en,
  input  logic [15:0]   sr_wr_data,
  input  logic          vbr_wr_en,
  input  logic [31:0]   vbr_wr_data,
  input  logic          sp_wr_en,
  input  logic [31:0]   sp_wr_data,
  output logic          mem_we,
  output logic [31:0]   mem_waddr,
  output logic [31:0]   mem_wdata,
  output logic          mem_re,
  output logic [31:0]   mem_raddr,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [31:0]   handler_pc,
  output logic [15:0]   sr,
  output logic          supervisor,
  output logic [31:0]   active_sp
);
  logic        entry, ent_irq, rte_ld, srw, sp_ld, dec, swap;
  logic [15:0] sr_q;
  logic [31:0] act_q, oth_q;

  exc_ctrl #(.VW(VW), .PRIV_VEC(PRIV_VEC), .VBR_MASK(VBR_MASK)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .exc_req(exc_req), .exc_vec(exc_vec), .exc_irq(exc_irq), .exc_pc(exc_pc),
    .rte_req(rte_req), .sr_wr_en(sr_wr_en),
    .vbr_wr_en(vbr_wr_en), .vbr_wr_data(vbr_wr_data), .sp_wr_en(sp_wr_en),
    .sr_q(sr_q), .act_sp(act_q), .mem_rdata(mem_rdata),
    .entry(entry), .ent_irq(ent_irq), .rte_ld(rte_ld), .srw(srw),
    .sp_ld(sp_ld), .dec(dec),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr),
    .busy(busy), .done(done), .handler_pc(handler_pc)
  );

  exc_sr_reg #(.RESET_SR(RESET_SR)) u_sr (
    .clk(clk), .rst_n(rst_n),
    .entry(entry), .ent_irq(ent_irq), .lvl(exc_lvl),
    .rte_ld(rte_ld), .rte_val(rte_sr),
    .srw(srw), .wr_val(sr_wr_data),
    .sr_q(sr_q), .swap(swap)
  );

  exc_sp_bank #(.AW(32)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .swap(swap), .dec(dec), .wr_en(sp_ld), .wr_data(sp_wr_data),
    .act_q(act_q), .oth_q(oth_q)
  );

  assign sr         = sr_q;
  assign supervisor = sr_q[SR_SUPER];
  assign active_sp  = act_q;

  // R11
  no_update_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dec) |=> (sr_q == $past(sr_q) && act_q == $past(act_q)));
endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, exc_irq, rte_req, sr_wr_en, vbr_wr_en, sp_wr_en;
  logic [7:0]  exc_vec;
  logic [2:0]  exc_lvl;
  logic [31:0] exc_pc, vbr_wr_data, sp_wr_data;
  logic [15:0] rte_sr, sr_wr_data;
  logic        mem_we, mem_re, busy, done, supervisor;
  logic [31:0] mem_waddr, mem_wdata, mem_raddr, handler_pc, active_sp;
  logic [31:0] mem_rdata = 32'd0;
  logic [15:0] sr;

  int n_chk = 0;
  int n_err = 0;
  int wcnt = 0;
  int rcnt = 0;
  logic [31:0] wa [4];
  logic [31:0] wd [4];
  logic [31:0] last_ra = 32'd0;

  logic [15:0] m_sr;
  logic [31:0] m_asp, m_osp, m_vbr;

  always #2 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n),
    .exc_req(exc_req), .exc_vec(exc_vec), .exc_irq(exc_irq), .exc_lvl(exc_lvl),
    .exc_pc(exc_pc), .rte_req(rte_req), .rte_sr(rte_sr),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .vbr_wr_en(vbr_wr_en), .vbr_wr_data(vbr_wr_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .handler_pc(handler_pc),
    .sr(sr), .supervisor(supervisor), .active_sp(active_sp)
  );

  function automatic logic [31:0] tbl(input logic [31:0] a);
    return (a * 32'd3) ^ 32'h1357_0000;
  endfunction

  function automatic logic [15:0] f_entry(input logic [15:0] s, input bit irq, input logic [2:0] l);
    logic [15:0] n;
    n = s;
    n[13] = 1'b1;
    n[15] = 1'b0;
    if (irq) begin
      n[12] = 1'b0;
      n[10:8] = l;
    end
    return n;
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= tbl(mem_raddr);
      last_ra   <= mem_raddr;
      rcnt      <= rcnt + 1;
    end
    if (mem_we) begin
      wa[wcnt % 4] <= mem_waddr;
      wd[wcnt % 4] <= mem_wdata;
      wcnt         <= wcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    exc_req = 0; exc_irq = 0; rte_req = 0; sr_wr_en = 0; vbr_wr_en = 0; sp_wr_en = 0;
    exc_vec = 0; exc_lvl = 0; exc_pc = 0; rte_sr = 0; sr_wr_data = 0;
    vbr_wr_data = 0; sp_wr_data = 0;
  endtask

  task automatic swap_model();
    logic [31:0] t;
    t = m_asp; m_asp = m_osp; m_osp = t;
  endtask

  // inputs are already driven for one cycle by the caller
  task automatic finish_entry(input logic [7:0] vec, input bit irq, input logic [2:0] lvl,
                              input logic [31:0] pc, input bit poke, input string req);
    logic [15:0] saved;
    logic [31:0] base;
    int w0, r0, k;
    saved = m_sr;
    if (!m_sr[13]) swap_model();
    m_sr = f_entry(m_sr, irq, lvl);
    base = m_asp;
    m_asp = m_asp - 32'd8;
    w0 = wcnt; r0 = rcnt;
    @(negedge clk);
    clear_in();
    chk({req, " sr after accept"}, {16'd0, sr}, {16'd0, m_sr});
    chk("R11 busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      exc_req = 1; exc_vec = vec ^ 8'h55; sr_wr_en = 1; sr_wr_data = 16'h0000;
      rte_req = 1; rte_sr = 16'h0000; vbr_wr_en = 1; vbr_wr_data = 32'hFFFF_FFFF;
      sp_wr_en = 1; sp_wr_data = 32'h0BAD_0000;
      @(negedge clk);
      clear_in();
    end
    k = 0;
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk("R5 done pulse", {31'd0, done}, 32'd1);
    chk("R5 handler pc", handler_pc, tbl(m_vbr + {22'd0, vec, 2'b00}));
    chk("R6 fetch address", last_ra, m_vbr + {22'd0, vec, 2'b00});
    chk("R5 one read", rcnt - r0, 32'd1);
    chk("R4 write count", wcnt - w0, 32'd2);
    chk("R4 word0 addr", wa[w0 % 4], base - 32'd8);
    chk("R4 word0 data", wd[w0 % 4], {4'h4, 4'h0, vec, saved});
    chk("R4 word1 addr", wa[(w0 + 1) % 4], base - 32'd4);
    chk("R4 word1 data", wd[(w0 + 1) % 4], pc);
    chk("R4 sp after entry", active_sp, m_asp);
    chk("R11 sr kept while busy", {16'd0, sr}, {16'd0, m_sr});
    chk("R11 idle after done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R5 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic op_exc(input logic [7:0] vec, input bit irq, input logic [2:0] lvl,
                        input logic [31:0] pc, input bit poke);
    exc_req = 1; exc_vec = vec; exc_irq = irq; exc_lvl = lvl; exc_pc = pc;
    finish_entry(vec, irq, lvl, pc, poke, irq ? "R3" : "R2");
  endtask

  task automatic op_rte(input logic [15:0] v, input logic [31:0] pc);
    rte_req = 1; rte_sr = v; exc_pc = pc;
    if (!m_sr[13]) begin
      finish_entry(8'd8, 0, 3'd0, pc, 0, "R10 rte");
    end else begin
      @(negedge clk);
      clear_in();
      if ((v[13]) != m_sr[13]) swap_model();
      m_sr = v & 16'hB7FF;
      chk("R8 rte load", {16'd0, sr}, {16'd0, m_sr});
      chk("R7 sp after rte", active_sp, m_asp);
    end
  endtask

  task automatic op_srw(input logic [15:0] v);
    sr_wr_en = 1; sr_wr_data = v;
    @(negedge clk);
    clear_in();
    if (m_sr[13]) begin
      if (v[13] != m_sr[13]) swap_model();
      m_sr = v & 16'hB7FF;
      chk("R8 supervisor sr write", {16'd0, sr}, {16'd0, m_sr});
    end else begin
      m_sr = {m_sr[15:8], v[7:0]};
      chk("R9 user sr write", {16'd0, sr}, {16'd0, m_sr});
    end
    chk("R7 sp after sr write", active_sp, m_asp);
  endtask

  task automatic op_vbr(input logic [31:0] v, input logic [31:0] pc);
    vbr_wr_en = 1; vbr_wr_data = v; exc_pc = pc;
    if (!m_sr[13]) begin
      finish_entry(8'd8, 0, 3'd0, pc, 0, "R10 vbr");
    end else begin
      @(negedge clk);
      clear_in();
      m_vbr = v & 32'h0080_0000;
    end
  endtask

  task automatic op_sp(input logic [31:0] v);
    sp_wr_en = 1; sp_wr_data = v;
    @(negedge clk);
    clear_in();
    m_asp = v;
    chk("R12 sp write", active_sp, m_asp);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4242);
    clear_in();
    rst_n = 0;
    m_sr = 16'h2700; m_asp = 0; m_osp = 0; m_vbr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset sr", {16'd0, sr}, 32'h0000_2700);
    chk("R1 reset sp", active_sp, 32'd0);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);

    op_sp(32'h0000_1000);
    op_exc(8'd3, 0, 3'd0, 32'h0000_4000, 0);        // R1 base zero, R2
    op_exc(8'd64, 1, 3'd5, 32'h0000_4100, 0);       // R3
    op_srw(16'hFFFF);                               // R8 reserved forced low
    op_srw(16'h0012);                               // R7 to user, swap
    op_sp(32'h0000_2000);                           // user pointer
    op_srw(16'hFFAB);                               // R9 only low byte
    op_exc(8'd255, 1, 3'd7, 32'h0000_4200, 0);      // R7 swap back, R3
    op_vbr(32'hFFFF_FFFF, 32'h0);                   // R6
    op_exc(8'd10, 0, 3'd0, 32'h0000_4300, 1);       // R11 poke while busy
    op_rte(16'h0004, 32'h0);                        // R7 return to user
    chk("R7 user pointer restored", active_sp, 32'h0000_2000);
    op_rte(16'h2000, 32'h0000_5000);                // R10 user return
    op_srw(16'h0000);
    op_vbr(32'h0000_0000, 32'h0000_5100);           // R10 user base write
    op_vbr(32'h0000_0000, 32'h0);                   // R6 back to zero

    for (int i = 0; i < 80; i++) begin
      int sel;
      sel = $urandom % 6;
      case (sel)
        0, 1: op_exc(8'($urandom), 1'($urandom), 3'($urandom), $urandom, 1'($urandom));
        2: op_rte(16'($urandom), $urandom);
        3: op_srw(16'($urandom));
        4: op_vbr($urandom, $urandom);
        default: op_sp({16'h0001, 12'($urandom), 4'h0});
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule